// File: doc/BRIEF.md
# Load-Store Queue with Address Disambiguation

This block holds memory operations for an out-of-order core in the order they were dispatched. Each entry is either a load or a store. It carries a base operand, an offset and, for a store, a data operand. The base and data operands may still be waiting on a producer when the entry is dispatched; in that case the entry holds the producer's tag. The queue watches the result bus and picks up each waiting operand when a matching tag is broadcast. Each entry has its own adder, which forms the effective address as soon as the base value is present.

Each cycle the queue looks for the oldest entry that is ready and safe to send to data memory. An entry is safe when no older entry it could conflict with has the same address or an address that is not yet known. Loads therefore pass older loads freely, and they pass stores whose addresses are known to differ. A load that memory accepts places its destination tag and the returned data on the result outputs in the next cycle. A store that memory accepts produces nothing on those outputs. When an entry leaves, the entries behind it close the gap and keep their relative order. A full flag holds back dispatch.

Top module: `lsq_top`

## Requirements
- R1: After reset the queue is empty: `full_o`=0, `mem_req_o`=0 and `ld_valid_o`=0.
- R2: An entry's memory address is base plus offset, modulo 2^DW (for example 0xFFF0 + 0x0020 gives 0x0010). An entry whose base is not yet known never requests memory.
- R3: A waiting base or data operand takes `cdb_data_i` on the first cycle in which `cdb_valid_i` is high and `cdb_tag_i` equals its tag. This includes the cycle in which the entry itself is dispatched.
- R4: A load may issue only when no older store in the queue has the same address or an unknown address. Older loads never hold it back.
- R5: A store may issue only when its data operand is known and no older entry, load or store, has the same address or an unknown address.
- R6: Among the entries allowed to issue, the oldest is presented. `mem_we_o` is 1 for a store and 0 for a load. A store presents its data on `mem_wdata_o`; a load presents its destination tag on `mem_tag_o`.
- R7: When `mem_req_o` and `mem_ack_i` are both high at a clock edge, the presented entry is removed and the entries that remain keep their program order.
- R8: `full_o` is high when all DEPTH entries are occupied. A dispatch while `full_o` is high is ignored.
- R9: A load accepted at a clock edge drives `ld_valid_o` high for the following cycle, with `ld_tag_o` set to its destination tag and `ld_data_o` set to the `mem_rdata_i` sampled at acceptance. An accepted store leaves `ld_valid_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disp_valid_i | input | 1 | Dispatch a new entry |
| disp_store_i | input | 1 | 1 = store, 0 = load |
| disp_base_rdy_i | input | 1 | Base value is present |
| disp_base_i | input | DW | Base value |
| disp_base_tag_i | input | TW | Tag of the base producer |
| disp_offset_i | input | DW | Address offset |
| disp_data_rdy_i | input | 1 | Store data is present |
| disp_data_i | input | DW | Store data value |
| disp_data_tag_i | input | TW | Tag of the store data producer |
| disp_dst_tag_i | input | TW | Destination tag of a load |
| full_o | output | 1 | All entries occupied |
| cdb_valid_i | input | 1 | Result bus broadcast valid |
| cdb_tag_i | input | TW | Result bus tag |
| cdb_data_i | input | DW | Result bus value |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a store |
| mem_addr_o | output | DW | Request address |
| mem_wdata_o | output | DW | Store data |
| mem_tag_o | output | TW | Load destination tag |
| mem_ack_i | input | 1 | Memory accepts the request |
| mem_rdata_i | input | DW | Load data, valid at acceptance |
| ld_valid_o | output | 1 | Load result broadcast |
| ld_tag_o | output | TW | Load result tag |
| ld_data_o | output | DW | Load result data |

## Verification
The bench uses the default build: DEPTH=4, DW=16 and TW=4. With four entries the queue reaches its full state after four dispatches, and removal from the middle can be observed across three entries. The bench sweeps every pairing of an older blocker with a younger load or store. The older blocker is a load with an unknown address, a store with an unknown address, or a store whose address is known but whose data is pending. Each pairing runs with the same address and with a different address. Sixteen-bit addresses make the adder's wrap-around cheap to reach.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
  // Two memory ops need ordering unless both are loads.
  function automatic logic must_order(input logic older_st, input logic younger_st);
    return older_st | younger_st;
  endfunction
endpackage

// File: rtl/lsq_agu.sv
module lsq_agu #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] base_i,
  input  logic [DW-1:0] off_i,
  output logic [DW-1:0] addr_o
);
  assign addr_o = base_i + off_i;
endmodule

// File: rtl/lsq_hazard.sv
module lsq_hazard
  import lsq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int DW    = 16
) (
  input  logic [DEPTH-1:0]         valid_i,
  input  logic [DEPTH-1:0]         st_i,
  input  logic [DEPTH-1:0]         brdy_i,
  input  logic [DEPTH-1:0]         drdy_i,
  input  logic [DEPTH-1:0][DW-1:0] addr_i,
  output logic [DEPTH-1:0]         elig_o
);
  logic [DEPTH-1:0] blk;

  // Index 0 is oldest; an unknown older address counts as a match.
  always_comb begin
    blk = '0;
    for (int i = 0; i < DEPTH; i++) begin
      for (int j = 0; j < i; j++) begin
        if (valid_i[j] && must_order(st_i[j], st_i[i]) &&
            (!brdy_i[j] || addr_i[j] == addr_i[i]))
          blk[i] = 1'b1;
      end
      elig_o[i] = valid_i[i] && brdy_i[i] && drdy_i[i] && !blk[i];
    end
  end
endmodule

// File: rtl/lsq_pick.sv
module lsq_pick #(
  parameter int DEPTH = 4,
  parameter int IW    = 2
) (
  input  logic [DEPTH-1:0] req_i,
  output logic [DEPTH-1:0] grant_o,
  output logic [IW-1:0]    idx_o,
  output logic             any_o
);
  always_comb begin
    grant_o = '0;
    idx_o   = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        grant_o    = '0;
        grant_o[i] = 1'b1;
        idx_o      = IW'(i);
      end
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/lsq_top.sv
module lsq_top #(
  parameter int DEPTH = 4,
  parameter int DW    = 16,
  parameter int TW    = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          disp_valid_i,
  input  logic          disp_store_i,
  input  logic          disp_base_rdy_i,
  input  logic [DW-1:0] disp_base_i,
  input  logic [TW-1:0] disp_base_tag_i,
  input  logic [DW-1:0] disp_offset_i,
  input  logic          disp_data_rdy_i,
  input  logic [DW-1:0] disp_data_i,
  input  logic [TW-1:0] disp_data_tag_i,
  input  logic [TW-1:0] disp_dst_tag_i,
  output logic          full_o,
  input  logic          cdb_valid_i,
  input  logic [TW-1:0] cdb_tag_i,
  input  logic [DW-1:0] cdb_data_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic [TW-1:0] mem_tag_o,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          ld_valid_o,
  output logic [TW-1:0] ld_tag_o,
  output logic [DW-1:0] ld_data_o
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] count_q, count_d, wr_idx;
  logic [DEPTH-1:0] st_q, brdy_q, drdy_q, st_d, brdy_d, drdy_d, s_brdy, s_drdy;
  logic [DEPTH-1:0][DW-1:0] base_q, off_q, data_q, base_d, off_d, data_d, s_base, s_data;
  logic [DEPTH-1:0][TW-1:0] btag_q, dtag_q, dst_q, btag_d, dtag_d, dst_d;
  logic [DEPTH-1:0] valid, elig, grant;
  logic [DEPTH-1:0][DW-1:0] addr;
  logic [IW-1:0] pick_idx;
  logic any, push, pop;
  logic in_brdy, in_drdy;
  logic [DW-1:0] in_base, in_data;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) valid[i] = (CW'(i) < count_q);
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_agu
    lsq_agu #(.DW(DW)) u_agu (
      .base_i(base_q[g]),
      .off_i (off_q[g]),
      .addr_o(addr[g])
    );
  end

  lsq_hazard #(.DEPTH(DEPTH), .DW(DW)) u_hazard (
    .valid_i(valid),
    .st_i   (st_q),
    .brdy_i (brdy_q),
    .drdy_i (drdy_q),
    .addr_i (addr),
    .elig_o (elig)
  );

  lsq_pick #(.DEPTH(DEPTH), .IW(IW)) u_pick (
    .req_i  (elig),
    .grant_o(grant),
    .idx_o  (pick_idx),
    .any_o  (any)
  );

  assign full_o      = (count_q == CW'(DEPTH));
  assign push        = disp_valid_i && !full_o;
  assign mem_req_o   = any;
  assign mem_we_o    = st_q[pick_idx];
  assign mem_addr_o  = addr[pick_idx];
  assign mem_wdata_o = data_q[pick_idx];
  assign mem_tag_o   = dst_q[pick_idx];
  assign pop         = mem_req_o && mem_ack_i;

  // Same-cycle bus bypass for dispatched operands.
  assign in_brdy = disp_base_rdy_i || (cdb_valid_i && cdb_tag_i == disp_base_tag_i);
  assign in_base = disp_base_rdy_i ? disp_base_i : cdb_data_i;
  assign in_drdy = !disp_store_i || disp_data_rdy_i ||
                   (cdb_valid_i && cdb_tag_i == disp_data_tag_i);
  assign in_data = disp_data_rdy_i ? disp_data_i : cdb_data_i;

  always_comb begin
    s_brdy = brdy_q;
    s_base = base_q;
    s_drdy = drdy_q;
    s_data = data_q;
    for (int i = 0; i < DEPTH; i++) begin
      if (cdb_valid_i && !brdy_q[i] && btag_q[i] == cdb_tag_i) begin
        s_brdy[i] = 1'b1;
        s_base[i] = cdb_data_i;
      end
      if (cdb_valid_i && !drdy_q[i] && dtag_q[i] == cdb_tag_i) begin
        s_drdy[i] = 1'b1;
        s_data[i] = cdb_data_i;
      end
    end
    st_d   = st_q;
    brdy_d = s_brdy;
    base_d = s_base;
    drdy_d = s_drdy;
    data_d = s_data;
    off_d  = off_q;
    btag_d = btag_q;
    dtag_d = dtag_q;
    dst_d  = dst_q;
    // compact over the removed slot
    for (int i = 0; i < DEPTH - 1; i++) begin
      if (pop && i >= int'(pick_idx)) begin
        st_d[i]   = st_q[i+1];
        brdy_d[i] = s_brdy[i+1];
        base_d[i] = s_base[i+1];
        drdy_d[i] = s_drdy[i+1];
        data_d[i] = s_data[i+1];
        off_d[i]  = off_q[i+1];
        btag_d[i] = btag_q[i+1];
        dtag_d[i] = dtag_q[i+1];
        dst_d[i]  = dst_q[i+1];
      end
    end
    wr_idx = count_q - CW'(pop);
    if (push) begin
      st_d[wr_idx[IW-1:0]]   = disp_store_i;
      brdy_d[wr_idx[IW-1:0]] = in_brdy;
      base_d[wr_idx[IW-1:0]] = in_base;
      drdy_d[wr_idx[IW-1:0]] = in_drdy;
      data_d[wr_idx[IW-1:0]] = in_data;
      off_d[wr_idx[IW-1:0]]  = disp_offset_i;
      btag_d[wr_idx[IW-1:0]] = disp_base_tag_i;
      dtag_d[wr_idx[IW-1:0]] = disp_data_tag_i;
      dst_d[wr_idx[IW-1:0]]  = disp_dst_tag_i;
    end
    count_d = count_q + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      st_q    <= '0;
      brdy_q  <= '0;
      drdy_q  <= '0;
      base_q  <= '0;
      off_q   <= '0;
      data_q  <= '0;
      btag_q  <= '0;
      dtag_q  <= '0;
      dst_q   <= '0;
    end else begin
      count_q <= count_d;
      st_q    <= st_d;
      brdy_q  <= brdy_d;
      drdy_q  <= drdy_d;
      base_q  <= base_d;
      off_q   <= off_d;
      data_q  <= data_d;
      btag_q  <= btag_d;
      dtag_q  <= dtag_d;
      dst_q   <= dst_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_valid_o <= 1'b0;
      ld_tag_o   <= '0;
      ld_data_o  <= '0;
    end else begin
      ld_valid_o <= pop && !mem_we_o;
      if (pop && !mem_we_o) begin
        ld_tag_o  <= mem_tag_o;
        ld_data_o <= mem_rdata_i;
      end
    end
  end

  AST_FULL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && disp_valid_i && !pop |=> full_o); // R8
  AST_LD_BCAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop && !mem_we_o |=> ld_valid_o && ld_tag_o == $past(mem_tag_o)); // R9
  AST_ST_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop && mem_we_o |=> !ld_valid_o); // R9
  AST_PICK_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant) && (mem_req_o == (grant != '0))); // R6
  AST_STORE_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> drdy_q[pick_idx]); // R5
  AST_BASE_KNOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> brdy_q[pick_idx] && valid[pick_idx]); // R2
  AST_POP_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop && !push |=> count_q == $past(count_q) - CW'(1)); // R7
endmodule

// File: tb/tb_lsq_top.sv
module tb_lsq_top;
  localparam int DW = 16;
  localparam int TW = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic disp_valid_i = 0, disp_store_i = 0, disp_base_rdy_i = 0, disp_data_rdy_i = 0;
  logic [DW-1:0] disp_base_i = 0, disp_offset_i = 0, disp_data_i = 0;
  logic [TW-1:0] disp_base_tag_i = 0, disp_data_tag_i = 0, disp_dst_tag_i = 0;
  logic full_o;
  logic cdb_valid_i = 0;
  logic [TW-1:0] cdb_tag_i = 0;
  logic [DW-1:0] cdb_data_i = 0;
  logic mem_req_o, mem_we_o, mem_ack_i = 0;
  logic [DW-1:0] mem_addr_o, mem_wdata_o, mem_rdata_i = 0;
  logic [TW-1:0] mem_tag_o;
  logic ld_valid_o;
  logic [TW-1:0] ld_tag_o;
  logic [DW-1:0] ld_data_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  lsq_top #(.DEPTH(4), .DW(DW), .TW(TW)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .disp_valid_i(disp_valid_i), .disp_store_i(disp_store_i),
    .disp_base_rdy_i(disp_base_rdy_i), .disp_base_i(disp_base_i),
    .disp_base_tag_i(disp_base_tag_i), .disp_offset_i(disp_offset_i),
    .disp_data_rdy_i(disp_data_rdy_i), .disp_data_i(disp_data_i),
    .disp_data_tag_i(disp_data_tag_i), .disp_dst_tag_i(disp_dst_tag_i),
    .full_o(full_o),
    .cdb_valid_i(cdb_valid_i), .cdb_tag_i(cdb_tag_i), .cdb_data_i(cdb_data_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_tag_o(mem_tag_o),
    .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
    .ld_valid_o(ld_valid_o), .ld_tag_o(ld_tag_o), .ld_data_o(ld_data_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic disp(input logic st, input logic brdy, input logic [DW-1:0] base,
                      input logic [TW-1:0] btag, input logic [DW-1:0] off,
                      input logic drdy, input logic [DW-1:0] data,
                      input logic [TW-1:0] dtag, input logic [TW-1:0] dst);
    disp_valid_i = 1; disp_store_i = st; disp_base_rdy_i = brdy; disp_base_i = base;
    disp_base_tag_i = btag; disp_offset_i = off; disp_data_rdy_i = drdy;
    disp_data_i = data; disp_data_tag_i = dtag; disp_dst_tag_i = dst;
    @(negedge clk);
    disp_valid_i = 0;
  endtask

  task automatic bus(input logic [TW-1:0] tag, input logic [DW-1:0] val);
    cdb_valid_i = 1; cdb_tag_i = tag; cdb_data_i = val;
    @(negedge clk);
    cdb_valid_i = 0;
  endtask

  task automatic accept(input logic [DW-1:0] rd);
    mem_ack_i = 1; mem_rdata_i = rd;
    @(negedge clk);
    mem_ack_i = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 full", full_o, 0);
    chk("R1 req", mem_req_o, 0);
    chk("R1 ldvalid", ld_valid_o, 0);

    // R2 wrap-around address, and no request before the base is known
    disp(0, 0, 0, 7, 16'h0020, 1, 0, 0, 3);
    chk("R2 no req without base", mem_req_o, 0);
    bus(7, 16'hFFF0);
    chk("R2 req", mem_req_o, 1);
    chk("R2 addr wrap", mem_addr_o, 16'h0010);
    accept(16'h1234);
    chk("R9 ld valid", ld_valid_o, 1);
    chk("R9 ld tag", ld_tag_o, 3);
    chk("R9 ld data", ld_data_o, 16'h1234);

    // R3 bypass in the dispatch cycle
    do_reset();
    cdb_valid_i = 1; cdb_tag_i = 5; cdb_data_i = 16'h0040;
    disp(1, 0, 0, 5, 16'h0004, 0, 0, 5, 0);
    cdb_valid_i = 0;
    chk("R3 bypass req", mem_req_o, 1);
    chk("R3 bypass addr", mem_addr_o, 16'h0044);
    chk("R3 bypass data", mem_wdata_o, 16'h0040);
    accept(0);
    chk("R9 store silent", ld_valid_o, 0);

    // Pairwise sweep: older blocker kind x younger op x address match
    for (int k = 0; k < 3; k++) begin
      for (int ys = 0; ys < 2; ys++) begin
        for (int sm = 0; sm < 2; sm++) begin
          logic [DW-1:0] ya;
          logic exp_y;
          do_reset();
          ya = (sm != 0) ? 16'h0108 : 16'h010C;
          if (k == 0)      disp(0, 0, 0, 1, 16'h0008, 1, 0, 0, 9);
          else if (k == 1) disp(1, 0, 0, 1, 16'h0008, 1, 16'h1111, 0, 9);
          else             disp(1, 1, 16'h0100, 0, 16'h0008, 0, 0, 2, 9);
          disp(ys[0], 1, 16'h0100, 0, ya - 16'h0100, 1, 16'h2222, 0, 10);
          if (k == 0)      exp_y = (ys == 0);
          else if (k == 1) exp_y = 0;
          else             exp_y = (sm == 0);
          if (ys == 0) chk("R4 younger load gate", mem_req_o, exp_y);
          else         chk("R5 younger store gate", mem_req_o, exp_y);
          if (exp_y) chk("R4 bypass addr", mem_addr_o, ya);
          if (k < 2) bus(1, 16'h0100);
          else       bus(2, 16'h3333);
          chk("R6 oldest req", mem_req_o, 1);
          chk("R6 oldest addr", mem_addr_o, 16'h0108);
          chk("R6 oldest we", mem_we_o, (k != 0));
          if (k == 1) chk("R6 wdata", mem_wdata_o, 16'h1111);
          if (k == 2) chk("R3 data snoop", mem_wdata_o, 16'h3333);
          accept(16'hBEEF);
          chk("R9 older bcast", ld_valid_o, (k == 0));
          if (k == 0) begin
            chk("R9 older tag", ld_tag_o, 9);
            chk("R9 older data", ld_data_o, 16'hBEEF);
          end
          chk("R7 younger req", mem_req_o, 1);
          chk("R7 younger addr", mem_addr_o, ya);
          chk("R6 younger we", mem_we_o, ys);
          accept(16'hCAFE);
          chk("R9 younger bcast", ld_valid_o, (ys == 0));
          chk("R7 empty", mem_req_o, 0);
        end
      end
    end

    // R7 removal from the middle keeps order
    do_reset();
    disp(1, 1, 16'h0200, 0, 0, 0, 0, 6, 0);
    disp(0, 1, 16'h0210, 0, 0, 1, 0, 0, 11);
    disp(0, 1, 16'h0220, 0, 0, 1, 0, 0, 12);
    chk("R4 load passes store", mem_addr_o, 16'h0210);
    chk("R6 tag", mem_tag_o, 11);
    accept(16'h0001);
    chk("R7 next load addr", mem_addr_o, 16'h0220);
    chk("R7 next load tag", mem_tag_o, 12);
    accept(16'h0002);
    chk("R9 second ld data", ld_data_o, 16'h0002);
    chk("R5 store waits data", mem_req_o, 0);
    bus(6, 16'h00AA);
    chk("R7 store addr", mem_addr_o, 16'h0200);
    chk("R6 store wdata", mem_wdata_o, 16'h00AA);
    accept(0);
    chk("R7 drained", mem_req_o, 0);

    // R8 full and ignored dispatch
    do_reset();
    for (int i = 0; i < 4; i++)
      disp(1, 1, 16'h0300 + 16'(i * 4), 0, 0, 0, 0, 3, 0);
    chk("R8 full", full_o, 1);
    disp(0, 1, 16'h0400, 0, 0, 1, 0, 0, 1);
    chk("R8 still full", full_o, 1);
    bus(3, 16'h5555);
    for (int i = 0; i < 4; i++) begin
      chk("R7 drain order", mem_addr_o, 16'h0300 + 16'(i * 4));
      chk("R8 drain data", mem_wdata_o, 16'h5555);
      accept(0);
    end
    chk("R8 dropped dispatch", mem_req_o, 0);
    chk("R8 not full", full_o, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule